// File: doc/BRIEF.md
# Grouped Interrupt Event Controller

This block collects single-cycle event pulses from a network controller's datapath into a sticky event register. Software clears the register by writing ones. Each latched event is gated by its own enable bit in a mask register. The gated events are then folded into three level-sensitive interrupt lines: one for transmit frames, one for receive frames, and one for errors, diagnostics and special functions.

The transmit-frame and receive-frame completion events each pass through a coalescing unit before they reach their line. When a unit is enabled, it holds back the frame-complete contribution until one of two things happens: a programmed number of frames has arrived, or a programmed number of clock ticks has passed since the first held-back frame. The buffer events on the same line are not held back. A small register bus gives access to the event register, the mask and the two coalescing configurations.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: A pulse on `evt_in[i]` sets event bit i on the next clock edge, and the bit stays set until software clears it. Bit map: 0 transmit-buffer, 1 transmit-frame, 2 receive-buffer, 3 receive-frame, 4..24 error/diagnostic/special group.
- R2: A bus write to offset 0x0 clears every event bit whose `wdata` bit is 1. Bits written with 0 keep their value.
- R3: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: A read with `rd_en` places data on `rdata` one cycle later. Offsets are 0x0 event, 0x4 mask, 0x8 transmit coalescing, 0xC receive coalescing. The event register reads the same whatever the mask holds. Bits 31..25 of event and mask read 0. All registers reset to 0.
- R5: An event bit drives an interrupt only while its mask bit is 1. Every interrupt output is registered and follows the event register by one cycle.
- R6: `irq_tx` is high when masked transmit-buffer is set, or when masked transmit-frame is set and the transmit coalescing unit has released it. A disabled unit releases at once. The line stays high until both bits are cleared.
- R7: `irq_rx` follows the same rule using receive-buffer, receive-frame and the receive coalescing unit.
- R8: `irq_err` is the OR of masked bits 4..24. It drops only when every one of them is clear or masked.
- R9: Coalescing config layout: bit 31 enable, bits 23:16 frame threshold, bits 15:0 timer threshold. An enabled unit releases on the frame pulse that brings its count to the threshold. A frame threshold of 0 acts as 1.
- R10: An enabled unit with a nonzero timer threshold T releases on the T-th clock edge after the first held-back frame. T = 0 disables the timeout.
- R11: The frame count and the timer restart after a release, once the frame bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 25 | Event pulses, one bit per event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_tx | output | 1 | Transmit frame interrupt |
| irq_rx | output | 1 | Receive frame interrupt |
| irq_err | output | 1 | Error/diagnostic/special interrupt |

## Verification
The bench sets and clears a bit in the same cycle. A design that gives the clear priority would lose that event, and the read-back would show the bit as 0. It clears the two bits of a frame line one at a time and clears error bits one by one. A design that drops the line on the first clear would show the line low too early. For coalescing, it sends a run of frames below the threshold and checks the line stays low. It then clears the frame bit and sends a new run. A unit that kept its old count would release early on the new run. It also counts the exact timeout edge and checks that a timer threshold of 0 never times out. An off-by-one timer, or a design that treats 0 as an immediate timeout, would show up as an early or a missing interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_EVT   = 25;
  localparam int TXB_BIT   = 0;
  localparam int TXF_BIT   = 1;
  localparam int RXB_BIT   = 2;
  localparam int RXF_BIT   = 3;
  localparam int ERR_LO    = 4;
  localparam int NUM_PATH  = 2;   // 0: transmit, 1: receive
  localparam int FRM_W     = 8;
  localparam int TMR_W     = 16;
  localparam int CFG_EN_POS  = 31;
  localparam int CFG_FRM_LSB = 16;
  localparam int CFG_TMR_LSB = 0;

  // Offset index (addr[3:2])
  localparam logic [1:0] SEL_EVT  = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_TXC  = 2'd2;
  localparam logic [1:0] SEL_RXC  = 2'd3;

  localparam logic [NUM_EVT-1:0] ERR_GROUP = {{(NUM_EVT-ERR_LO){1'b1}}, {ERR_LO{1'b0}}};

  typedef struct packed {
    logic             en;
    logic [FRM_W-1:0] frm_thr;
    logic [TMR_W-1:0] tmr_thr;
  } coal_cfg_t;
endpackage

// File: rtl/irq_event_reg.sv
module irq_event_reg #(
  parameter int N = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // Set wins over clear so that no event is lost.
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o & ~clr_i) | set_i;
  end

  assert_sticky_set_R1: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  assert_hold_unless_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));

  assert_clear_takes_R2: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int FRM_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [FRM_W-1:0] frm_thr_i,
  input  logic [TMR_W-1:0] tmr_thr_i,
  input  logic             pulse_i,      // raw frame-complete pulse
  input  logic             frame_bit_i,  // latched frame event bit
  output logic             release_o
);
  logic [FRM_W-1:0] cnt_q, cnt_base, cnt_n, thr_eff;
  logic [TMR_W-1:0] tmr_q, tmr_base, tmr_n;
  logic             met_q, met_base, met_n;
  logic [FRM_W:0]   cnt_sum;
  logic [TMR_W:0]   tmr_sum;

  always_comb begin
    // A cleared frame bit restarts the unit.
    cnt_base = frame_bit_i ? cnt_q : '0;
    tmr_base = frame_bit_i ? tmr_q : '0;
    met_base = frame_bit_i & met_q;
    thr_eff  = (frm_thr_i == '0) ? FRM_W'(1) : frm_thr_i;
    cnt_sum  = {1'b0, cnt_base} + {{FRM_W{1'b0}}, pulse_i};
    tmr_sum  = {1'b0, tmr_base} + {{TMR_W{1'b0}}, 1'b1};
    cnt_n    = cnt_base;
    tmr_n    = tmr_base;
    met_n    = met_base;
    if (!en_i) begin
      cnt_n = '0;
      tmr_n = '0;
      met_n = 1'b0;
    end else if (!met_base) begin
      if (pulse_i && (cnt_sum >= {1'b0, thr_eff})) begin
        met_n = 1'b1;
        cnt_n = '0;
        tmr_n = '0;
      end else if ((cnt_base != '0) && (tmr_thr_i != '0) &&
                   (tmr_sum >= {1'b0, tmr_thr_i})) begin
        met_n = 1'b1;
        cnt_n = '0;
        tmr_n = '0;
      end else begin
        cnt_n = cnt_sum[FRM_W-1:0];
        tmr_n = (cnt_base != '0) ? tmr_sum[TMR_W-1:0] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tmr_q <= '0;
      met_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tmr_q <= tmr_n;
      met_q <= met_n;
    end
  end

  assign release_o = ~en_i | met_q;

  assert_release_has_frame_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(met_q) |-> frame_bit_i);

  assert_disabled_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !met_q);

  assert_restart_on_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (!frame_bit_i && !pulse_i) |=> (!met_q && cnt_q == '0));
endmodule

// File: rtl/irq_group_out.sv
module irq_group_out
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_q_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  logic [NUM_PATH-1:0] rel_i,
  output logic               irq_tx_o,
  output logic               irq_rx_o,
  output logic               irq_err_o
);
  logic [NUM_EVT-1:0] act;
  assign act = evt_q_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx_o  <= 1'b0;
      irq_rx_o  <= 1'b0;
      irq_err_o <= 1'b0;
    end else begin
      irq_tx_o  <= act[TXB_BIT] | (act[TXF_BIT] & rel_i[0]);
      irq_rx_o  <= act[RXB_BIT] | (act[RXF_BIT] & rel_i[1]);
      irq_err_o <= |(act & ERR_GROUP);
    end
  end

  assert_tx_negate_R6: assert property (@(posedge clk) disable iff (rst)
    (!evt_q_i[TXB_BIT] && !evt_q_i[TXF_BIT]) |=> !irq_tx_o);

  assert_rx_negate_R7: assert property (@(posedge clk) disable iff (rst)
    (!evt_q_i[RXB_BIT] && !evt_q_i[RXF_BIT]) |=> !irq_rx_o);

  assert_err_negate_R8: assert property (@(posedge clk) disable iff (rst)
    ((evt_q_i & mask_i & ERR_GROUP) == '0) |=> !irq_err_o);

  assert_masked_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> (!irq_tx_o && !irq_rx_o && !irq_err_o));
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_tx,
  output logic               irq_rx,
  output logic               irq_err
);
  localparam int SEL_LSB = 2;

  logic [1:0]          sel;
  logic [NUM_EVT-1:0]  evt_q, mask_q, clr;
  coal_cfg_t           cfg_q [NUM_PATH];
  logic [NUM_PATH-1:0] frm_pulse, frm_bit, rel;
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_bits;

  assign sel         = addr[SEL_LSB +: 2];
  assign unused_bits = ^{wdata, addr};
  assign clr         = (wr_en && sel == SEL_EVT) ? wdata[NUM_EVT-1:0] : '0;

  irq_event_reg #(.N(NUM_EVT)) u_evt (
    .clk(clk), .rst(rst), .set_i(evt_in), .clr_i(clr), .q_o(evt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      for (int p = 0; p < NUM_PATH; p++) cfg_q[p] <= '0;
    end else if (wr_en) begin
      if (sel == SEL_MASK) mask_q <= wdata[NUM_EVT-1:0];
      for (int p = 0; p < NUM_PATH; p++) begin
        if (sel == ((p == 0) ? SEL_TXC : SEL_RXC)) begin
          cfg_q[p].en      <= wdata[CFG_EN_POS];
          cfg_q[p].frm_thr <= wdata[CFG_FRM_LSB +: FRM_W];
          cfg_q[p].tmr_thr <= wdata[CFG_TMR_LSB +: TMR_W];
        end
      end
    end
  end

  assign frm_pulse = {evt_in[RXF_BIT], evt_in[TXF_BIT]};
  assign frm_bit   = {evt_q[RXF_BIT],  evt_q[TXF_BIT]};

  for (genvar g = 0; g < NUM_PATH; g++) begin : g_coal
    irq_coalesce #(.FRM_W(FRM_W), .TMR_W(TMR_W)) u_coal (
      .clk(clk), .rst(rst),
      .en_i(cfg_q[g].en), .frm_thr_i(cfg_q[g].frm_thr), .tmr_thr_i(cfg_q[g].tmr_thr),
      .pulse_i(frm_pulse[g]), .frame_bit_i(frm_bit[g]), .release_o(rel[g])
    );
  end

  irq_group_out u_out (
    .clk(clk), .rst(rst), .evt_q_i(evt_q), .mask_i(mask_q), .rel_i(rel),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );

  function automatic logic [DATA_W-1:0] pack_cfg(input coal_cfg_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CFG_EN_POS]              = c.en;
    v[CFG_FRM_LSB +: FRM_W]    = c.frm_thr;
    v[CFG_TMR_LSB +: TMR_W]    = c.tmr_thr;
    return v;
  endfunction

  always_comb begin
    case (sel)
      SEL_EVT:  rd_mux = DATA_W'(evt_q);
      SEL_MASK: rd_mux = DATA_W'(mask_q);
      SEL_TXC:  rd_mux = pack_cfg(cfg_q[0]);
      default:  rd_mux = pack_cfg(cfg_q[1]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (sel == SEL_EVT || sel == SEL_MASK)) |=> (rdata[DATA_W-1:NUM_EVT] == '0));
endmodule

// File: tb/sim_grouped_irq_ctrl.sv
module sim_grouped_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [24:0] evt_in;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_tx, irq_rx, irq_err;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  grouped_irq_ctrl u0 (
    .clk(clk), .rst(rst), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  // {set pulses, clearing write, expected event register}, mask = 0
  localparam logic [95:0] VEC [10] = '{
    {32'h0000_0013, 32'h0000_0000, 32'h0000_0013},  // R1 set
    {32'h0100_0000, 32'h0000_0000, 32'h0100_0013},  // R1 top bit, others kept
    {32'h0000_0000, 32'h0000_0002, 32'h0100_0011},  // R2 single clear
    {32'h0000_0010, 32'h0000_0010, 32'h0100_0011},  // R3 set and clear same cycle
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 clear all
    {32'h01FF_FFFF, 32'h0000_0000, 32'h01FF_FFFF},  // R1 all bits
    {32'h0000_0000, 32'h0000_0000, 32'h01FF_FFFF},  // R2 write of zero
    {32'h0000_0000, 32'h01FF_FFF0, 32'h0000_000F},  // R2 group clear
    {32'h0000_0005, 32'h0000_000F, 32'h0000_0005},  // R3 mixed
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}   // R2
  };

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int b);
    evt_in = 25'(1) << b;
    tick();
    evt_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; evt_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R4 reset values
    chk("R4 reset irqs", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), d);
      chk("R4 reset register", d, 32'h0);
    end

    // Table walk: R1 R2 R3 with mask cleared (R5)
    for (int i = 0; i < 10; i++) begin
      evt_in = VEC[i][88:64];
      wr_en = 1'b1; addr = 4'h0; wdata = VEC[i][63:32];
      tick();
      evt_in = '0; wr_en = 1'b0; wdata = '0;
      rd(4'h0, d);
      chk("R1/R2/R3 table event", d, VEC[i][31:0]);
      chk("R5 table irqs masked", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
    end

    // R4 mask readback, reserved bits zero
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d);
    chk("R4 mask readback", d, 32'h01FF_FFFF);

    // R8 error group
    pulse(10); tick();
    chk("R8 err asserts", {31'b0, irq_err}, 32'h1);
    chk("R8 tx/rx quiet", {30'b0, irq_tx, irq_rx}, 32'h0);
    pulse(20); tick();
    wr(4'h0, 32'h0000_0400); tick();
    chk("R8 err held by remaining bit", {31'b0, irq_err}, 32'h1);
    wr(4'h0, 32'h0010_0000); tick();
    chk("R8 err negates", {31'b0, irq_err}, 32'h0);

    // R5 masked bit still visible (R4)
    wr(4'h4, 32'h01FF_FF7F);
    pulse(7); tick(); tick();
    chk("R5 masked bit silent", {31'b0, irq_err}, 32'h0);
    rd(4'h0, d);
    chk("R4 read ignores mask", d, 32'h0000_0080);
    wr(4'h0, 32'h0000_0080);
    wr(4'h4, 32'hFFFF_FFFF);

    // R6 no coalescing
    pulse(0); tick();
    chk("R6 tx on buffer", {30'b0, irq_tx, irq_rx}, 32'h2);
    pulse(1);
    wr(4'h0, 32'h0000_0001); tick();
    chk("R6 tx held by frame bit", {31'b0, irq_tx}, 32'h1);
    wr(4'h0, 32'h0000_0002); tick();
    chk("R6 tx negates", {31'b0, irq_tx}, 32'h0);

    // R7 receive
    pulse(3); tick();
    chk("R7 rx on frame", {30'b0, irq_tx, irq_rx}, 32'h1);
    pulse(2);
    wr(4'h0, 32'h0000_0008); tick();
    chk("R7 rx held by buffer bit", {31'b0, irq_rx}, 32'h1);
    wr(4'h0, 32'h0000_0004); tick();
    chk("R7 rx negates", {31'b0, irq_rx}, 32'h0);

    // R9 count threshold 3 on transmit
    wr(4'h8, 32'h8003_0000);
    rd(4'h8, d);
    chk("R4 tx cfg readback", d, 32'h8003_0000);
    pulse(1); tick();
    chk("R9 held after 1 frame", {31'b0, irq_tx}, 32'h0);
    pulse(1); tick();
    chk("R9 held after 2 frames", {31'b0, irq_tx}, 32'h0);
    pulse(1); tick();
    chk("R9 release at threshold", {31'b0, irq_tx}, 32'h1);

    // R11 restart after clearing
    wr(4'h0, 32'h0000_0002); tick();
    chk("R11 tx drops on clear", {31'b0, irq_tx}, 32'h0);
    pulse(1); tick();
    pulse(1); tick();
    chk("R11 count restarted", {31'b0, irq_tx}, 32'h0);
    pulse(1); tick();
    chk("R11 release on new run", {31'b0, irq_tx}, 32'h1);
    wr(4'h0, 32'h0000_0002); tick();

    // R10 timeout of 10 ticks, count threshold 200
    wr(4'h8, 32'h80C8_000A);
    pulse(1);
    repeat (10) tick();
    chk("R10 not before timeout", {31'b0, irq_tx}, 32'h0);
    tick();
    chk("R10 release on timeout", {31'b0, irq_tx}, 32'h1);
    wr(4'h0, 32'h0000_0002); tick();

    // R6 buffer event bypasses coalescing
    pulse(0); tick();
    chk("R6 buffer not coalesced", {31'b0, irq_tx}, 32'h1);
    wr(4'h0, 32'h0000_0001); tick();

    // R9 threshold zero acts as one
    wr(4'hC, 32'h8000_0000);
    rd(4'hC, d);
    chk("R4 rx cfg readback", d, 32'h8000_0000);
    pulse(3); tick();
    chk("R9 zero threshold releases", {31'b0, irq_rx}, 32'h1);
    wr(4'h0, 32'h0000_0008); tick();

    // R10 timer zero never times out
    wr(4'hC, 32'h8002_0000);
    pulse(3);
    repeat (50) tick();
    chk("R10 zero timer no timeout", {31'b0, irq_rx}, 32'h0);
    pulse(3); tick();
    chk("R9 rx release at count", {31'b0, irq_rx}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule